// File: doc/BRIEF.md
# Carry-Steered Absolute Difference Front End

This block is the first stage of a sum-of-absolute-differences datapath for block matching. It accepts a vector of lanes. Each lane carries one pair of unsigned 8-bit pixel values, A and B. For each pair it returns two 8-bit operands, X and Y, chosen so that X + Y + 1 equals 256 + |A − B|.

The block never forms a signed difference and never negates a result. Each lane works out only the carry-out of A + ~B + 1 with generate/propagate logic. That carry shows which input is the smaller one. The smaller input is then bit-inverted and the larger one passes through unchanged. The final add and the per-lane "+1" are left to the downstream adder tree. The deferred ones are offered to that tree as a single constant term, equal to the lane count, on `out_bias`. The tree has to drop the 256 offset of each lane, for example by truncating the sum of a 256-lane block to 16 bits.

All lanes share one valid flag and one output register stage. There is no backpressure. A parameter selects how the carry is formed: a bit-serial chain or a two-level grouped lookahead.

Top module: `absd_front`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_x` and `out_y` are all zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: For a lane captured with A > B, the lane field of `out_x` is A and the lane field of `out_y` is the bitwise inverse of B. Lane l occupies bits [8l+7:8l] of every packed vector.
- R4: For a lane captured with A < B, the lane field of `out_x` is the bitwise inverse of A and the lane field of `out_y` is B.
- R5: For every captured lane, X + Y + 1, computed at 9 bits or wider, equals 256 + |A − B|.
- R6: For a lane captured with A equal to B, the carry is 1, so `out_x` is A and `out_y` is the inverse of A, and the pair sums to 255.
- R7: Each lane's outputs depend only on that lane's own inputs. Lanes with opposite orderings in the same cycle each follow R3 or R4 on their own.
- R8: A cycle with `in_valid` low leaves `out_x` and `out_y` unchanged, whatever data is present, and `out_valid` drops to 0.
- R9: `out_bias` equals the number of lanes, which is the count of deferred ones.
- R10: The bit-serial carry style and the grouped lookahead carry style give identical outputs for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The input pair vector is valid this cycle |
| in_a | input | LANES*PIX_W | Current-block pixels, lane l at bits [PIX_W*l +: PIX_W] |
| in_b | input | LANES*PIX_W | Reference-block pixels, same lane layout |
| out_valid | output | 1 | Registered operands are valid |
| out_x | output | LANES*PIX_W | First operand of each lane (A, or inverted A) |
| out_y | output | LANES*PIX_W | Second operand of each lane (inverted B, or B) |
| out_bias | output | $clog2(LANES+1) | Constant count of deferred ones for the adder tree |

## Verification
Four lanes sweep all 65536 ordered pixel pairs. This covers both orderings, the A = B diagonal and the extremes 0 and 255, so the A > B, A < B and tie selection rules are each told apart from a wrong steering choice or from a carry that is off by one bit. A cycle whose lanes hold opposite orderings shows whether the lanes interact. An idle cycle carrying fresh data shows whether data is captured when it should not be. A second instance built with the other carry style is compared output for output with the first, so a fault in either carry network shows up as a mismatch.

// File: rtl/absd_pkg.sv
package absd_pkg;
   typedef enum int {
      CARRY_SERIAL  = 0,
      CARRY_GROUPED = 1
   } carry_style_e;

   localparam int unsigned DEF_PIX_W   = 8;
   localparam int unsigned DEF_GROUP_W = 4;
endpackage

// File: rtl/absd_carry_gen.sv
// Carry-out of a + ~b + 1 without forming the sum.
module absd_carry_gen
   import absd_pkg::*;
#(
   parameter int unsigned  PIX_W       = DEF_PIX_W,
   parameter int unsigned  GROUP_W     = DEF_GROUP_W,
   parameter carry_style_e CARRY_STYLE = CARRY_GROUPED
) (
   input  logic [PIX_W-1:0] a,
   input  logic [PIX_W-1:0] b,
   output logic             carry
);
   localparam int unsigned N_GROUPS = PIX_W / GROUP_W;

   if (PIX_W < 2) begin : g_bad_width
      $error("absd_carry_gen: PIX_W must be at least 2");
   end
   if (GROUP_W < 1 || (PIX_W % GROUP_W) != 0) begin : g_bad_group
      $error("absd_carry_gen: GROUP_W must divide PIX_W");
   end

   // generate/propagate against the inverted subtrahend
   logic [PIX_W-1:0] gen_b;
   logic [PIX_W-1:0] prop_b;
   assign gen_b  = a & ~b;
   assign prop_b = a | ~b;

   if (CARRY_STYLE == CARRY_SERIAL) begin : g_serial
      logic [PIX_W:0] chain;
      assign chain[0] = 1'b1;
      for (genvar i = 0; i < PIX_W; i++) begin : g_bit
         assign chain[i+1] = gen_b[i] | (prop_b[i] & chain[i]);
      end
      assign carry = chain[PIX_W];
   end else begin : g_grouped
      logic [N_GROUPS-1:0] grp_g;
      logic [N_GROUPS-1:0] grp_p;
      logic [N_GROUPS:0]   grp_c;
      for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_grp
         always_comb begin
            logic g_acc;
            logic p_acc;
            g_acc = 1'b0;
            p_acc = 1'b1;
            for (int k = 0; k < int'(GROUP_W); k++) begin
               g_acc = gen_b[gi*GROUP_W+k] | (prop_b[gi*GROUP_W+k] & g_acc);
               p_acc = p_acc & prop_b[gi*GROUP_W+k];
            end
            grp_g[gi] = g_acc;
            grp_p[gi] = p_acc;
         end
      end
      assign grp_c[0] = 1'b1;
      for (genvar gj = 0; gj < N_GROUPS; gj++) begin : g_look
         assign grp_c[gj+1] = grp_g[gj] | (grp_p[gj] & grp_c[gj]);
      end
      assign carry = grp_c[N_GROUPS];
   end
endmodule

// File: rtl/absd_lane_steer.sv
// Inverts whichever operand the carry marks as the smaller one.
module absd_lane_steer #(
   parameter int unsigned PIX_W = absd_pkg::DEF_PIX_W
) (
   input  logic [PIX_W-1:0] a,
   input  logic [PIX_W-1:0] b,
   input  logic             b_not_above,
   output logic [PIX_W-1:0] x,
   output logic [PIX_W-1:0] y
);
   always_comb begin
      if (b_not_above) begin
         x = a;
         y = ~b;
      end else begin
         x = ~a;
         y = b;
      end
   end
endmodule

// File: rtl/absd_stage_reg.sv
module absd_stage_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("absd_stage_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/absd_front.sv
module absd_front
   import absd_pkg::*;
#(
   parameter int unsigned  LANES       = 256,
   parameter int unsigned  PIX_W       = DEF_PIX_W,
   parameter int unsigned  GROUP_W     = DEF_GROUP_W,
   parameter carry_style_e CARRY_STYLE = CARRY_GROUPED,
   localparam int unsigned BIAS_W      = $clog2(LANES + 1),
   localparam int unsigned VEC_W       = LANES * PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  in_a,
   input  logic [VEC_W-1:0]  in_b,
   output logic              out_valid,
   output logic [VEC_W-1:0]  out_x,
   output logic [VEC_W-1:0]  out_y,
   output logic [BIAS_W-1:0] out_bias
);
   if (LANES < 1) begin : g_bad_lanes
      $error("absd_front: LANES must be positive");
   end

   logic [VEC_W-1:0] x_comb;
   logic [VEC_W-1:0] y_comb;
   logic [LANES-1:0] lane_carry;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      absd_carry_gen #(
         .PIX_W      (PIX_W),
         .GROUP_W    (GROUP_W),
         .CARRY_STYLE(CARRY_STYLE)
      ) u_cg (
         .a    (in_a[l*PIX_W +: PIX_W]),
         .b    (in_b[l*PIX_W +: PIX_W]),
         .carry(lane_carry[l])
      );

      absd_lane_steer #(.PIX_W(PIX_W)) u_steer (
         .a          (in_a[l*PIX_W +: PIX_W]),
         .b          (in_b[l*PIX_W +: PIX_W]),
         .b_not_above(lane_carry[l]),
         .x          (x_comb[l*PIX_W +: PIX_W]),
         .y          (y_comb[l*PIX_W +: PIX_W])
      );
   end

   absd_stage_reg #(.W(VEC_W)) u_reg_x (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .d(x_comb), .q(out_x)
   );
   absd_stage_reg #(.W(VEC_W)) u_reg_y (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .d(y_comb), .q(out_y)
   );
   absd_stage_reg #(.W(1)) u_reg_v (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(in_valid), .q(out_valid)
   );

   assign out_bias = BIAS_W'(LANES);
endmodule

// File: rtl/absd_front_chk.sv
module absd_front_chk #(
   parameter int unsigned LANES = 256,
   parameter int unsigned PIX_W = 8,
   localparam int unsigned VEC_W = LANES * PIX_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VEC_W-1:0] in_a,
   input logic [VEC_W-1:0] in_b,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_x,
   input logic [VEC_W-1:0] out_y
);
   // R1: reset clears the registered outputs
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (!out_valid && out_x == '0 && out_y == '0)
            else $error("R1 reset state violated");
      end
   end

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_x) && $stable(out_y)));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      p_pick_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_a[l*PIX_W +: PIX_W] >= in_b[l*PIX_W +: PIX_W]) |=>
         (out_x[l*PIX_W +: PIX_W] == $past(in_a[l*PIX_W +: PIX_W]) &&
          out_y[l*PIX_W +: PIX_W] == ~$past(in_b[l*PIX_W +: PIX_W])));
      p_pick_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_a[l*PIX_W +: PIX_W] < in_b[l*PIX_W +: PIX_W]) |=>
         (out_x[l*PIX_W +: PIX_W] == ~$past(in_a[l*PIX_W +: PIX_W]) &&
          out_y[l*PIX_W +: PIX_W] == $past(in_b[l*PIX_W +: PIX_W])));
      p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |->
         ((PIX_W+1)'(out_x[l*PIX_W +: PIX_W]) + (PIX_W+1)'(out_y[l*PIX_W +: PIX_W])
          + (PIX_W+1)'(1)) >= (PIX_W+1)'(1 << PIX_W));
   end
endmodule

bind absd_front absd_front_chk #(.LANES(LANES), .PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
   .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
);

// File: tb/absd_front_test.sv
`timescale 1ns/1ps
module absd_front_test;
   import absd_pkg::*;
   localparam int L  = 4;
   localparam int W  = 8;
   localparam int VW = L * W;
   localparam int BW = $clog2(L + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] in_a = '0;
   logic [VW-1:0] in_b = '0;
   logic          out_valid, out_valid2;
   logic [VW-1:0] out_x, out_y, out_x2, out_y2;
   logic [BW-1:0] out_bias, out_bias2;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   absd_front #(.LANES(L), .PIX_W(W), .GROUP_W(4), .CARRY_STYLE(CARRY_GROUPED)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_bias(out_bias)
   );
   absd_front #(.LANES(L), .PIX_W(W), .GROUP_W(2), .CARRY_STYLE(CARRY_SERIAL)) uut_serial (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid2), .out_x(out_x2), .out_y(out_y2), .out_bias(out_bias2)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // per-lane check of the registered operands against captured pairs
   task automatic check_lanes(input logic [VW-1:0] a_v, input logic [VW-1:0] b_v);
      for (int l = 0; l < L; l++) begin
         int a, b, x, y, ex, ey, d;
         a = int'(a_v[l*W +: W]);
         b = int'(b_v[l*W +: W]);
         x = int'(out_x[l*W +: W]);
         y = int'(out_y[l*W +: W]);
         if (a >= b) begin ex = a; ey = 255 - b; end
         else begin ex = 255 - a; ey = b; end
         d = (a >= b) ? a - b : b - a;
         if (a > b)       chk(x == ex && y == ey, "R3", x*256 + y, ex*256 + ey);
         else if (a < b)  chk(x == ex && y == ey, "R4", x*256 + y, ex*256 + ey);
         else             chk(x == ex && y == ey && x + y == 255, "R6", x*256 + y, ex*256 + ey);
         chk(x + y + 1 == 256 + d, "R5", x + y + 1, 256 + d);
      end
      chk(out_x2 == out_x && out_y2 == out_y, "R10", longint'(out_x2), longint'(out_x));
   endtask

   task automatic apply(input logic [VW-1:0] a_v, input logic [VW-1:0] b_v);
      @(negedge clk);
      in_a = a_v; in_b = b_v; in_valid = 1'b1;
      @(posedge clk); #1;
      chk(out_valid == 1'b1, "R2", out_valid, 1);
      check_lanes(a_v, b_v);
   endtask

   initial begin
      logic [VW-1:0] ha, hb, hx, hy;
      #1;
      chk(out_valid == 1'b0 && out_x == '0 && out_y == '0, "R1", longint'(out_x), 0);
      in_a = {VW{1'b1}}; in_valid = 1'b1;
      @(posedge clk); #1;
      chk(out_valid == 1'b0 && out_x == '0 && out_y == '0, "R1", longint'(out_x), 0);
      chk(out_bias == BW'(L) && out_bias2 == BW'(L), "R9", out_bias, L);
      @(negedge clk);
      in_valid = 1'b0; rst_n = 1'b1;

      // R7: opposite orderings side by side
      apply({8'd10, 8'd200, 8'd0, 8'd255}, {8'd200, 8'd10, 8'd255, 8'd0});

      // exhaustive sweep: pair index p -> a = p[15:8], b = p[7:0]
      for (int base = 0; base < 65536; base += L) begin
         logic [VW-1:0] av, bv;
         for (int l = 0; l < L; l++) begin
            av[l*W +: W] = W'((base + l) >> 8);
            bv[l*W +: W] = W'((base + l) & 255);
         end
         apply(av, bv);
      end

      // R8: idle cycle with fresh data must not disturb the operands
      hx = out_x; hy = out_y;
      @(negedge clk);
      in_valid = 1'b0; in_a = 32'h1234_5678; in_b = 32'h9abc_def0;
      @(posedge clk); #1;
      chk(out_x == hx && out_y == hy, "R8", longint'(out_x), longint'(hx));
      chk(out_valid == 1'b0, "R8", out_valid, 0);
      chk(out_valid == 1'b0, "R2", out_valid, 0);
      ha = 32'h00ff_8080; hb = 32'hff00_7f81;
      apply(ha, hb);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule